// File: doc/BRIEF.md
# Banked Memory Copy Sequencer

This block copies one bank of a banked non-volatile memory into a chosen bank of a second memory of the same shape. Each memory holds 32 banks of 64K bytes. A 5-bit select picks the source bank and a second, independent 5-bit select picks the destination bank. The full address on each side is the bank number joined above a 16-bit in-bank offset.

A rising edge on the start input launches a pass. The input may come straight from a pushbutton, because the block synchronises it first. One offset counter walks every location in ascending order. Each location takes four clock phases. In the first phase the address settles and the source byte is captured. The destination chip-select and write-enable are then decoded from the phase flops. Write-enable falls after the address is stable and rises one phase before the address moves on, so the destination stores the byte on that rising edge.

The source memory is only ever read, so its chip-select and output-enable are tied active and its write-enable is tied inactive. When the last offset has been written, the block parks with every destination strobe inactive. It raises done and holds it until the next start.

Top module: `nvcopy_top`

## Requirements
- R1: Source control is constant from reset onwards: srcCsN = 0, srcOeN = 0 and srcWeN = 1.
- R2: Each output address is {bank, offset}, with the bank in the top BANK_W bits. Both bank selects are captured when a pass launches. Changes to the selects during a pass have no effect on that pass.
- R3: startBtn passes through a two-flop synchroniser and then an edge detector. A rising edge launches a pass from the idle or finished state. A rising edge during a pass is ignored, so the pass still writes each location exactly once.
- R4: Each location occupies four clock cycles, phases 0 to 3, and the address is constant through all four. dstWeN is low in phases 1 and 2 only. dstCsN is low in phases 1, 2 and 3. Consecutive write-enable rising edges are therefore exactly 4 cycles apart.
- R5: wrData is the source byte sampled at the end of phase 0. It is held unchanged while dstWeN is low, so the destination receives the source byte of the same offset.
- R6: A pass writes offsets 0 to 2^OFFS_W-1 in ascending order, each exactly once. No destination bank other than the selected one is touched.
- R7: After the last location, busy falls, done = 1, and dstWeN = dstCsN = 1. This state holds, with no further writes, until the next start edge.
- R8: After reset, busy = 0, done = 0, dstWeN = 1 and dstCsN = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startBtn | input | 1 | Asynchronous start request; a rising edge launches a pass |
| srcBankSel | input | BANK_W (5) | Source bank number |
| dstBankSel | input | BANK_W (5) | Destination bank number |
| rdData | input | DATA_W (8) | Byte read from the source memory |
| srcAddr | output | BANK_W+OFFS_W (21) | Source memory address |
| srcCsN | output | 1 | Source chip-select, active low, tied active |
| srcOeN | output | 1 | Source output-enable, active low, tied active |
| srcWeN | output | 1 | Source write-enable, active low, tied inactive |
| dstAddr | output | BANK_W+OFFS_W (21) | Destination memory address |
| wrData | output | DATA_W (8) | Byte driven to the destination |
| dstCsN | output | 1 | Destination chip-select, active low |
| dstWeN | output | 1 | Destination write-enable, active low; data stored on its rise |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | The last pass finished; held until the next start |

## Verification
On every cycle the assertions check the strobe timing. The destination address must not move on either edge of write-enable, and the outgoing byte must stay frozen while write-enable is low. The captured bank numbers must stay fixed during a pass, the source controls must stay at their tied levels, and the strobes must be idle while done is high. Only the bench scenarios can show that the right byte lands at the right offset, that every offset is written exactly once, and that other destination banks are untouched. The same applies to start presses and select changes made mid-pass being ignored, and to done persisting with no stray writes afterwards.

// File: rtl/nvcopy_pkg.sv
package nvcopy_pkg;
  // Strobes from the sequencer to the address/data path
  typedef struct packed {
    logic clearOffs;   // restart offset at zero
    logic takeBanks;   // capture bank selects
    logic takeData;    // sample source byte
    logic stepOffs;    // move to next offset
  } seqStrobe_t;

  localparam int PHASE_W = 2;  // four phases per location
endpackage

// File: rtl/nvcopy_ctrl.sv
module nvcopy_ctrl
  import nvcopy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBtn,
  input  logic       lastOffs,
  output seqStrobe_t strb,
  output logic       dstWeN,
  output logic       dstCsN,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_FIN} seqState_t;

  localparam logic [PHASE_W-1:0] PH_LAST = '1;

  seqState_t         state;
  logic [PHASE_W-1:0] phase;
  logic [2:0]        syncQ;
  logic              startEdge;
  logic              launch;
  logic              copying;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], startBtn};
  end

  assign startEdge = syncQ[1] & ~syncQ[2];
  assign copying   = (state == ST_COPY);
  assign launch    = startEdge && !copying;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else begin
      case (state)
        ST_COPY: begin
          phase <= phase + 1'b1;
          if (phase == PH_LAST && lastOffs) state <= ST_FIN;
        end
        default: begin
          phase <= '0;
          if (startEdge) state <= ST_COPY;
        end
      endcase
    end
  end

  always_comb begin
    strb.clearOffs = launch;
    strb.takeBanks = launch;
    strb.takeData  = copying && (phase == '0);
    strb.stepOffs  = copying && (phase == PH_LAST);
  end

  assign dstWeN = ~(copying && (phase == 2'd1 || phase == 2'd2));
  assign dstCsN = ~(copying && (phase != '0));
  assign busy   = copying;
  assign done   = (state == ST_FIN);

  // R7
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (dstWeN && dstCsN && !busy));

  // R4
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dstWeN) |-> $fell(dstCsN));
endmodule

// File: rtl/nvcopy_path.sv
module nvcopy_path
  import nvcopy_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int OFFS_W = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              busy,
  input  logic [BANK_W-1:0] srcBankSel,
  input  logic [BANK_W-1:0] dstBankSel,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastOffs
);
  logic [BANK_W-1:0] srcBankQ, dstBankQ;
  logic [OFFS_W-1:0] offs;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcBankQ <= '0;
      dstBankQ <= '0;
    end else if (strb.takeBanks) begin
      srcBankQ <= srcBankSel;
      dstBankQ <= dstBankSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              offs <= '0;
    else if (strb.clearOffs) offs <= '0;
    else if (strb.stepOffs)  offs <= offs + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataQ <= '0;
    else if (strb.takeData) dataQ <= rdData;
  end

  assign srcAddr  = {srcBankQ, offs};
  assign dstAddr  = {dstBankQ, offs};
  assign wrData   = dataQ;
  assign lastOffs = &offs;

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(srcBankQ) && $stable(dstBankQ)));

  // R6
  offs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(offs)) |-> (offs == $past(offs) + 1'b1));
endmodule

// File: rtl/nvcopy_top.sv
module nvcopy_top
  import nvcopy_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int OFFS_W = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBtn,
  input  logic [BANK_W-1:0] srcBankSel,
  input  logic [BANK_W-1:0] dstBankSel,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              srcCsN,
  output logic              srcOeN,
  output logic              srcWeN,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              dstCsN,
  output logic              dstWeN,
  output logic              busy,
  output logic              done
);
  seqStrobe_t strb;
  logic       lastOffs;

  nvcopy_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startBtn(startBtn), .lastOffs(lastOffs),
    .strb(strb), .dstWeN(dstWeN), .dstCsN(dstCsN), .busy(busy), .done(done)
  );

  nvcopy_path #(.BANK_W(BANK_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .srcBankSel(srcBankSel), .dstBankSel(dstBankSel), .rdData(rdData),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .wrData(wrData), .lastOffs(lastOffs)
  );

  // Source memory is read-only here
  assign srcCsN = 1'b0;
  assign srcOeN = 1'b0;
  assign srcWeN = 1'b1;

  // R1
  src_tied_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcCsN && !srcOeN && srcWeN));

  // R4
  addr_at_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dstWeN) |-> $stable(dstAddr));

  // R4
  addr_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dstWeN) |-> $stable(dstAddr));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dstWeN && $past(!dstWeN)) |-> $stable(wrData));
endmodule

// File: tb/test_nvcopy_top.sv
module test_nvcopy_top;
  localparam int BANK_W = 5;
  localparam int OFFS_W = 6;
  localparam int DATA_W = 8;
  localparam int ADDR_W = BANK_W + OFFS_W;
  localparam int BANK_SZ = 1 << OFFS_W;
  localparam int MEM_SZ  = 1 << ADDR_W;

  // {srcBank, dstBank, seed}
  localparam logic [17:0] VEC [4] = '{
    {5'd0,  5'd31, 8'h11},
    {5'd31, 5'd0,  8'hC3},
    {5'd4,  5'd4,  8'h7E},
    {5'd17, 5'd9,  8'h00}
  };

  logic clk = 0;
  logic rstN = 0;
  logic startBtn = 0;
  logic [BANK_W-1:0] srcBankSel = '0, dstBankSel = '0;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [DATA_W-1:0] wrData;
  logic srcCsN, srcOeN, srcWeN, dstCsN, dstWeN, busy, done;

  logic [DATA_W-1:0] srcMem [MEM_SZ];
  logic [DATA_W-1:0] dstMem [MEM_SZ];

  int tests = 0, fails = 0;
  int wrCount = 0, bankErr = 0, gapErr = 0, holdErr = 0;
  int cyc = 0, lastRise = -1;
  logic [BANK_W-1:0] expDst = '0;
  logic wePrev = 1'b1;
  logic [ADDR_W-1:0] addrPrev = '0;

  always #10 clk = ~clk;

  nvcopy_top #(.BANK_W(BANK_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) i_nvcopy_top (
    .clk(clk), .rstN(rstN), .startBtn(startBtn),
    .srcBankSel(srcBankSel), .dstBankSel(dstBankSel), .rdData(rdData),
    .srcAddr(srcAddr), .srcCsN(srcCsN), .srcOeN(srcOeN), .srcWeN(srcWeN),
    .dstAddr(dstAddr), .wrData(wrData), .dstCsN(dstCsN), .dstWeN(dstWeN),
    .busy(busy), .done(done)
  );

  assign rdData = srcMem[srcAddr];

  // Destination device: stores on rising write-enable while selected
  always @(posedge dstWeN) begin
    if (rstN && dstCsN === 1'b0) begin
      dstMem[dstAddr] = wrData;
      wrCount++;
      if (dstAddr[ADDR_W-1:OFFS_W] != expDst) bankErr++;
    end
  end

  // Strobe timing monitor (R4)
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!wePrev && dstWeN) begin
        if (lastRise >= 0 && (cyc - lastRise) != 4) gapErr++;
        lastRise = cyc;
      end
      if (!wePrev && !dstWeN && dstAddr != addrPrev) holdErr++;
    end
    wePrev   = dstWeN;
    addrPrev = dstAddr;
  end

  function automatic logic [7:0] pat(input logic [7:0] s, input int a);
    return s ^ 8'(a * 7) ^ 8'(a >> 2);
  endfunction

  function automatic logic [7:0] srcBg(input int i);
    return 8'(i) + 8'h33;
  endfunction

  function automatic logic [7:0] dstBg(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fillMems(input logic [4:0] sb, input logic [7:0] seed);
    for (int i = 0; i < MEM_SZ; i++) begin
      srcMem[i] = srcBg(i);
      dstMem[i] = dstBg(i);
    end
    for (int o = 0; o < BANK_SZ; o++) srcMem[int'(sb) * BANK_SZ + o] = pat(seed, o);
  endtask

  task automatic press();
    @(negedge clk);
    startBtn = 1'b1;
    repeat (3) @(negedge clk);
    startBtn = 1'b0;
  endtask

  task automatic waitDone();
    for (int k = 0; k < BANK_SZ * 4 + 50; k++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  function automatic int bankMismatch(input logic [4:0] db, input logic [7:0] seed);
    int n = 0;
    for (int o = 0; o < BANK_SZ; o++)
      if (dstMem[int'(db) * BANK_SZ + o] !== pat(seed, o)) n++;
    return n;
  endfunction

  function automatic int otherChanged(input logic [4:0] db);
    int n = 0;
    for (int i = 0; i < MEM_SZ; i++)
      if ((i / BANK_SZ) != int'(db) && dstMem[i] !== dstBg(i)) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [4:0] sb, db;
    logic [7:0] sd;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 0 && done == 0, "R8 busy/done", {busy, done}, 0);
    chk(dstWeN == 1 && dstCsN == 1, "R8 dst strobes", {dstWeN, dstCsN}, 3);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!srcCsN && !srcOeN && srcWeN, "R1 source controls", {srcCsN, srcOeN, srcWeN}, 1);

    // Vector table: copies between various banks
    foreach (VEC[v]) begin
      {sb, db, sd} = VEC[v];
      fillMems(sb, sd);
      srcBankSel = sb;
      dstBankSel = db;
      expDst = db;
      wrCount = 0; bankErr = 0; gapErr = 0; holdErr = 0; lastRise = -1;
      press();
      repeat (20) @(negedge clk);
      chk(busy && !srcCsN && !srcOeN && srcWeN, "R1 source controls during pass", busy, 1);
      waitDone();
      chk(bankMismatch(db, sd) == 0, "R5 R6 destination contents", bankMismatch(db, sd), 0);
      chk(otherChanged(db) == 0 && bankErr == 0, "R2 R6 other banks untouched", otherChanged(db) + bankErr, 0);
      chk(wrCount == BANK_SZ, "R6 write count", wrCount, BANK_SZ);
      chk(gapErr == 0 && holdErr == 0, "R4 strobe timing", gapErr + holdErr, 0);
      chk(done && !busy && dstWeN && dstCsN, "R7 finished state", {done, busy, dstWeN, dstCsN}, 8 + 2 + 1);
    end

    // R7: done persists with no stray writes
    wrCount = 0;
    repeat (40) @(negedge clk);
    chk(done && wrCount == 0 && dstWeN && dstCsN, "R7 done held", wrCount, 0);

    // R3 / R2: second press and select changes mid-pass are ignored
    fillMems(5'd2, 8'h99);
    srcBankSel = 5'd2;
    dstBankSel = 5'd9;
    expDst = 5'd9;
    wrCount = 0; bankErr = 0;
    press();
    repeat (4) @(negedge clk);
    chk(busy && !done, "R3 launch clears done", {busy, done}, 2);
    repeat (30) @(negedge clk);
    srcBankSel = 5'd7;
    dstBankSel = 5'd20;
    press();
    waitDone();
    chk(bankMismatch(5'd9, 8'h99) == 0, "R2 captured banks used", bankMismatch(5'd9, 8'h99), 0);
    chk(otherChanged(5'd9) == 0 && bankErr == 0, "R2 bank change ignored", otherChanged(5'd9) + bankErr, 0);
    chk(wrCount == BANK_SZ, "R3 mid-pass start ignored", wrCount, BANK_SZ);

    // R3: a short pulse that the synchroniser catches launches a pass
    @(negedge clk);
    startBtn = 1'b1;
    @(negedge clk);
    startBtn = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1, "R3 single-cycle press", busy, 1);
    waitDone();

    // R8: reset mid-pass returns to the idle state
    press();
    repeat (10) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(!busy && !done && dstWeN && dstCsN, "R8 reset mid-pass", {busy, done, dstWeN, dstCsN}, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule